// File: doc/BRIEF.md
# Frame-synchronous lock-in correlator

This block turns a stream of infrared camera frames into two correlation images, an in-phase image and a quadrature image, for thermal fault localisation. A single frame counter, running modulo `N_FR` frames per lock-in period, does two jobs. It drives the bias-enable output that switches the periodic stimulus onto the device under test. It also selects a sine weight and a cosine weight for the frame being received. Every pixel is multiplied by both weights, and the two products are added into two per-pixel running sums held in on-chip memory.

Software pulses `start` together with a period count. The block then clears both images and waits for a frame that begins with start-of-frame. From that frame it accumulates whole lock-in periods, and at the end it raises `done` and streams the I/Q pairs out in raster order. The control sequence has five states. ST_IDLE moves to ST_CLEAR on `start`. ST_CLEAR walks every pixel address, writing zeros, and moves to ST_ACCUM after the last one. ST_ACCUM moves to ST_READOUT when the final pixel of the final period is taken. ST_READOUT moves to ST_DONE when the beat marked last is accepted. A `start` in any state goes back to ST_CLEAR.

Top module: `lockin_correlator`

## Requirements
- R1: The frame index starts at 0 after `start`. It advances by one each time the NPIX-th pixel of a frame is taken, and it wraps from N_FR-1 to 0.
- R2: `bias_en` is high in ST_ACCUM while the frame index is below N_FR/2. It is low in every other state.
- R3: The weight for frame index k is round(127·sin(2πk/N_FR)) for the I channel and round(127·cos(2πk/N_FR)) for the Q channel, each held as a signed 8-bit value with 7 fraction bits.
- R4: Each accepted pixel, taken as unsigned, is multiplied by both weights. The products are added with their sign to the I and Q sums of its address.
- R5: After a clear, pixels are discarded until a pixel flagged `pix_sof` is taken. A flagged pixel always goes to address 0, and the following pixels go to increasing addresses. A flagged pixel in the middle of a frame restarts the address and does not advance the frame index.
- R6: `num_periods` is sampled on `start`, and a value of 0 is treated as 1. Accumulation ends after exactly N_FR × periods complete frames.
- R7: `done` rises in the cycle after the last accumulated pixel and stays high until the next `start`. The NPIX results leave in raster order, with `out_last` on address NPIX-1. The output holds steady while `out_ready` is low.
- R8: `start` restarts the block from any state. It begins a clear that lasts NPIX cycles, during which `pix_ready` is low.
- R9: In ST_IDLE, and once `done` is high, `pix_ready` is high and pixels are consumed without changing either image.
- R10: After reset the block is in ST_IDLE: `pix_ready` is high and `bias_en`, `done`, `out_valid` and `out_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that clears and begins a measurement |
| num_periods | input | PER_W | Lock-in periods to accumulate (0 means 1) |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | Pixel stream ready |
| pix_data | input | PIX_W | Unsigned pixel value |
| pix_sof | input | 1 | First pixel of a frame |
| bias_en | output | 1 | Stimulus switch enable |
| done | output | 1 | Measurement finished |
| out_valid | output | 1 | Result stream valid |
| out_ready | input | 1 | Result stream ready |
| out_i | output | ACC_W | Signed in-phase sum |
| out_q | output | ACC_W | Signed quadrature sum |
| out_last | output | 1 | Last pixel of the result image |

## Verification
The bench sends a run of junk pixels before the first start-of-frame marker. A correlator that began accumulating at once would have its weights one phase off, and every I/Q pair would be wrong. A start-of-frame in the middle of a frame checks that the address restarts while the frame index holds; a design that counted that frame would end one frame early and drop `bias_en` at the wrong time. A period count of zero must give exactly one period. A second `start` in the middle of a run must leave no residue of the first run's sums. Pixels are sent during readout while `out_ready` is throttled, so a design that kept accumulating after `done`, or let the output change under backpressure, gives wrong values or a repeated beat.

// File: rtl/lkc_pkg.sv
package lkc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ACCUM,
        ST_READOUT,
        ST_DONE
    } lkc_state_e;

    localparam real TWO_PI = 6.283185307179586;
endpackage

// File: rtl/lkc_weight_lut.sv
module lkc_weight_lut #(
    parameter int N_FR = 8,
    localparam int FW = $clog2(N_FR)
) (
    input  logic [FW-1:0]      idx,
    output logic signed [7:0]  w_sin,
    output logic signed [7:0]  w_cos
);
    logic signed [7:0] sin_tab [N_FR];
    logic signed [7:0] cos_tab [N_FR];

    for (genvar k = 0; k < N_FR; k++) begin : g_w
        localparam real ANG = lkc_pkg::TWO_PI * real'(k) / real'(N_FR);
        localparam int  SV  = int'(127.0 * $sin(ANG));
        localparam int  CV  = int'(127.0 * $cos(ANG));
        assign sin_tab[k] = 8'(SV);
        assign cos_tab[k] = 8'(CV);
    end

    always_comb begin
        w_sin = sin_tab[idx];
        w_cos = cos_tab[idx];
    end
endmodule

// File: rtl/lkc_frame_seq.sv
module lkc_frame_seq #(
    parameter int N_FR  = 8,
    parameter int NPIX  = 192,
    parameter int PER_W = 4,
    localparam int AW = $clog2(NPIX),
    localparam int FW = $clog2(N_FR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PER_W-1:0] periods,
    input  logic             take,
    input  logic             sof,
    output logic             use_px,
    output logic [AW-1:0]    addr,
    output logic [FW-1:0]    fidx,
    output logic             last_end
);
    logic [AW-1:0]    addr_q;
    logic [FW-1:0]    fidx_q;
    logic [PER_W-1:0] pcnt_q, tgt_q;
    logic             in_frame_q;
    logic             frame_end, period_end;

    always_comb begin
        use_px     = take && (sof || in_frame_q);
        addr       = sof ? '0 : addr_q;
        frame_end  = use_px && (addr == AW'(NPIX - 1));
        period_end = frame_end && (fidx_q == FW'(N_FR - 1));
        last_end   = period_end && (pcnt_q == tgt_q - 1'b1);
        fidx       = fidx_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            fidx_q     <= '0;
            pcnt_q     <= '0;
            tgt_q      <= PER_W'(1);
            in_frame_q <= 1'b0;
        end else if (clr) begin
            addr_q     <= '0;
            fidx_q     <= '0;
            pcnt_q     <= '0;
            tgt_q      <= (periods == '0) ? PER_W'(1) : periods;
            in_frame_q <= 1'b0;
        end else if (use_px) begin
            if (frame_end) begin
                in_frame_q <= 1'b0;
                addr_q     <= '0;
                if (period_end) begin
                    fidx_q <= '0;
                    pcnt_q <= pcnt_q + 1'b1;
                end else begin
                    fidx_q <= fidx_q + 1'b1;
                end
            end else begin
                addr_q     <= addr + 1'b1;
                in_frame_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lkc_acc_bank.sv
module lkc_acc_bank #(
    parameter int NPIX   = 192,
    parameter int ACC_W  = 27,
    parameter int PROD_W = 21,
    localparam int AW = $clog2(NPIX)
) (
    input  logic                     clk,
    input  logic                     clr_we,
    input  logic [AW-1:0]            clr_addr,
    input  logic                     acc_we,
    input  logic [AW-1:0]            acc_addr,
    input  logic signed [PROD_W-1:0] acc_val,
    input  logic [AW-1:0]            rd_addr,
    output logic signed [ACC_W-1:0]  rd_data
);
    logic signed [ACC_W-1:0] mem [NPIX];

    always_ff @(posedge clk) begin
        if (clr_we)
            mem[clr_addr] <= '0;
        else if (acc_we)
            mem[acc_addr] <= mem[acc_addr] + ACC_W'(acc_val);
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/lockin_correlator.sv
module lockin_correlator
    import lkc_pkg::*;
#(
    parameter int N_FR   = 8,
    parameter int WIDTH  = 16,
    parameter int HEIGHT = 12,
    parameter int PIX_W  = 12,
    parameter int PER_W  = 4,
    parameter int ACC_W  = PIX_W + 8 + $clog2(N_FR * ((1 << PER_W) - 1))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PER_W-1:0] num_periods,
    input  logic             pix_valid,
    output logic             pix_ready,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             pix_sof,
    output logic             bias_en,
    output logic             done,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ACC_W-1:0] out_i,
    output logic [ACC_W-1:0] out_q,
    output logic             out_last
);
    localparam int NPIX   = WIDTH * HEIGHT;
    localparam int AW     = $clog2(NPIX);
    localparam int FW     = $clog2(N_FR);
    localparam int PROD_W = PIX_W + 9;

    lkc_state_e state, nxt;
    logic [AW-1:0] clr_q, rd_q, px_addr;
    logic [FW-1:0] fidx;
    logic          px_take, px_use, last_end;
    logic signed [7:0] w_sin, w_cos;
    logic signed [ACC_W-1:0] rd_data [2];

    assign px_take = pix_valid && (state == ST_ACCUM);

    lkc_frame_seq #(.N_FR(N_FR), .NPIX(NPIX), .PER_W(PER_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(start), .periods(num_periods),
        .take(px_take), .sof(pix_sof), .use_px(px_use), .addr(px_addr),
        .fidx(fidx), .last_end(last_end)
    );

    lkc_weight_lut #(.N_FR(N_FR)) u_lut (
        .idx(fidx), .w_sin(w_sin), .w_cos(w_cos)
    );

    for (genvar c = 0; c < 2; c++) begin : g_ch
        logic signed [7:0]        w;
        logic signed [PROD_W-1:0] prod;
        assign w    = (c == 0) ? w_sin : w_cos;
        assign prod = $signed({1'b0, pix_data}) * w;
        lkc_acc_bank #(.NPIX(NPIX), .ACC_W(ACC_W), .PROD_W(PROD_W)) u_bank (
            .clk(clk), .clr_we(state == ST_CLEAR), .clr_addr(clr_q),
            .acc_we(px_use && !start), .acc_addr(px_addr), .acc_val(prod),
            .rd_addr(rd_q), .rd_data(rd_data[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q <= '0;
            rd_q  <= '0;
        end else begin
            if (start)                  clr_q <= '0;
            else if (state == ST_CLEAR) clr_q <= clr_q + 1'b1;
            if (start)                                rd_q <= '0;
            else if (state == ST_READOUT && out_ready) rd_q <= rd_q + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_CLEAR;
            ST_CLEAR:   if (!start && clr_q == AW'(NPIX - 1)) nxt = ST_ACCUM;
            ST_ACCUM:   if (start) nxt = ST_CLEAR;
                        else if (last_end) nxt = ST_READOUT;
            ST_READOUT: if (start) nxt = ST_CLEAR;
                        else if (out_ready && rd_q == AW'(NPIX - 1)) nxt = ST_DONE;
            ST_DONE:    if (start) nxt = ST_CLEAR;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        pix_ready = 1'b1;
        bias_en   = 1'b0;
        done      = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        out_i     = rd_data[0];
        out_q     = rd_data[1];
        unique case (state)
            ST_IDLE:    ;
            ST_CLEAR:   pix_ready = 1'b0;
            ST_ACCUM:   bias_en = (fidx < FW'(N_FR / 2));
            ST_READOUT: begin
                done      = 1'b1;
                out_valid = 1'b1;
                out_last  = (rd_q == AW'(NPIX - 1));
            end
            ST_DONE:    done = 1'b1;
            default:    pix_ready = 1'b1;
        endcase
    end
endmodule

// File: rtl/lkc_checker.sv
module lkc_checker
    import lkc_pkg::*;
#(
    parameter int N_FR  = 8,
    parameter int ACC_W = 27,
    localparam int FW = $clog2(N_FR)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             pix_ready,
    input logic             bias_en,
    input logic             done,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ACC_W-1:0] out_i,
    input logic [ACC_W-1:0] out_q,
    input logic             out_last,
    input lkc_state_e       state,
    input logic [FW-1:0]    fidx
);
    // R1: within accumulation the frame index only steps by one, wrapping at N_FR
    a_r1_fidx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACCUM && $past(state) == ST_ACCUM && fidx != $past(fidx))
        |-> (int'(fidx) == (int'($past(fidx)) + 1) % N_FR));

    // R2: the stimulus turns off in accumulation exactly at the half period
    a_r2_bias_half: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bias_en) && state == ST_ACCUM) |-> (int'(fidx) == N_FR / 2));

    // R7: result beat is held under backpressure
    a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start)
        |=> (out_valid && $stable(out_i) && $stable(out_q) && $stable(out_last)));

    // R7: after the last beat the stream closes and done stays
    a_r7_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last && !start) |=> (done && !out_valid));

    // R8: a start is followed by the clearing pass
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start) |-> (!pix_ready && !done && !bias_en));
endmodule

bind lockin_correlator lkc_checker #(.N_FR(N_FR), .ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_ready(pix_ready),
    .bias_en(bias_en), .done(done), .out_valid(out_valid),
    .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
    .out_last(out_last), .state(state), .fidx(fidx)
);

// File: tb/sim_lockin_correlator.sv
module sim_lockin_correlator;
    localparam int NF    = 8;
    localparam int WD    = 16;
    localparam int HT    = 12;
    localparam int NPIX  = WD * HT;
    localparam int PIX_W = 12;
    localparam int PER_W = 4;
    localparam int ACC_W = PIX_W + 8 + $clog2(NF * ((1 << PER_W) - 1));

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [PER_W-1:0] num_periods = '0;
    logic pix_valid = 1'b0, pix_sof = 1'b0, out_ready = 1'b0;
    logic [PIX_W-1:0] pix_data = '0;
    logic pix_ready, bias_en, done, out_valid, out_last;
    logic [ACC_W-1:0] out_i, out_q;

    lockin_correlator #(.N_FR(NF), .WIDTH(WD), .HEIGHT(HT), .PIX_W(PIX_W),
                        .PER_W(PER_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .num_periods(num_periods),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .pix_sof(pix_sof), .bias_en(bias_en), .done(done),
        .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i),
        .out_q(out_q), .out_last(out_last)
    );

    always #2 clk = ~clk;

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference weights per R3, computed independently
    int ws [NF];
    int wc [NF];
    initial begin
        for (int k = 0; k < NF; k++) begin
            ws[k] = int'(127.0 * $sin(6.283185307179586 * k / NF));
            wc[k] = int'(127.0 * $cos(6.283185307179586 * k / NF));
        end
    end

    // Behavioural model: 0 idle, 1 clear, 2 accumulate, 3 readout, 4 done
    int m_mode = 0, m_cnt = 0, m_fidx = 0, m_per = 0, m_tgt = 1, m_addr = 0, m_rd = 0;
    bit m_inframe = 0;
    longint ei [NPIX];
    longint eq [NPIX];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_fidx = 0; m_rd = 0; m_inframe = 0;
        end else if (start) begin                       // R8 restart, R6 sample
            m_mode = 1; m_cnt = 0; m_fidx = 0; m_per = 0; m_rd = 0;
            m_inframe = 0; m_addr = 0;
            m_tgt = (num_periods == 0) ? 1 : int'(num_periods);
            for (int a = 0; a < NPIX; a++) begin ei[a] = 0; eq[a] = 0; end
        end else begin
            case (m_mode)
                1: begin
                    if (m_cnt == NPIX - 1) m_mode = 2;
                    m_cnt++;
                end
                2: if (pix_valid && (pix_sof || m_inframe)) begin  // R5
                    if (pix_sof) m_addr = 0;
                    ei[m_addr] += longint'(pix_data) * ws[m_fidx];  // R4
                    eq[m_addr] += longint'(pix_data) * wc[m_fidx];
                    if (m_addr == NPIX - 1) begin                   // R1
                        m_inframe = 0; m_addr = 0;
                        if (m_fidx == NF - 1) begin
                            m_fidx = 0; m_per++;
                            if (m_per == m_tgt) begin m_mode = 3; m_rd = 0; end
                        end else m_fidx++;
                    end else begin
                        m_addr++; m_inframe = 1;
                    end
                end
                3: if (out_ready) begin
                    if (m_rd == NPIX - 1) m_mode = 4; else m_rd++;
                end
                default: ;
            endcase
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(pix_ready == (m_mode != 1), "R8/ready", pix_ready, m_mode != 1);
            chk(bias_en == (m_mode == 2 && m_fidx < NF / 2), "R2 bias", bias_en,
                m_mode == 2 && m_fidx < NF / 2);
            chk(done == (m_mode >= 3), "R7 done", done, m_mode >= 3);
            chk(out_valid == (m_mode == 3), "R7 valid", out_valid, m_mode == 3);
            if (m_mode == 3) begin
                chk(longint'($signed(out_i)) == ei[m_rd], "R4 I (weights R3)",
                    longint'($signed(out_i)), ei[m_rd]);
                chk(longint'($signed(out_q)) == eq[m_rd], "R4 Q (weights R3)",
                    longint'($signed(out_q)), eq[m_rd]);
                chk(out_last == (m_rd == NPIX - 1), "R7 last", out_last, m_rd == NPIX - 1);
            end
        end
    end

    function automatic logic [PIX_W-1:0] pat(input int f, input int p, input int seed);
        int v;
        v = seed * 37 + p * 13 + (((f % NF) < NF / 2) ? 400 : 0);
        if (p == 50 && (f % NF) < NF / 2) v += 2000;
        if (seed == 9) v = (p == f % NF) ? 1 : 0;     // isolates each weight (R3)
        return PIX_W'(v);
    endfunction

    task automatic send_px(input logic [PIX_W-1:0] v, input bit sof);
        @(negedge clk);
        pix_valid = 1'b1; pix_data = v; pix_sof = sof;
    endtask

    task automatic idle_px();
        @(negedge clk);
        pix_valid = 1'b0; pix_sof = 1'b0;
    endtask

    task automatic send_frame(input int f, input int seed, input int count);
        for (int p = 0; p < count; p++) begin
            send_px(pat(f, p, seed), p == 0);
            if (p % 7 == 3) idle_px();
        end
        idle_px();
    endtask

    task automatic do_start(input int np);
        @(negedge clk);
        start = 1'b1; num_periods = PER_W'(np);
        @(negedge clk);
        start = 1'b0;
        repeat (NPIX + 1) @(negedge clk);
    endtask

    task automatic readout(input bit garbage);
        int beats = 0;
        fork
            begin
                for (int n = 0; n < 4 * NPIX; n++) begin
                    @(negedge clk);
                    out_ready = (n % 4) != 1;
                    if (out_valid && out_ready) beats++;
                    if (out_valid && out_ready && out_last) begin
                        @(negedge clk);
                        out_ready = 1'b0;
                        break;
                    end
                end
            end
            begin
                if (garbage)                            // R9 after done
                    for (int g = 0; g < 100; g++) send_px(PIX_W'(g * 91 + 7), g % 20 == 0);
                idle_px();
            end
        join
        chk(beats == NPIX, "R7 beat count", beats, NPIX);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(pix_ready == 1'b1, "R10 ready", pix_ready, 1);
        chk({bias_en, done, out_valid, out_last} == 4'b0, "R10 outputs",
            {bias_en, done, out_valid, out_last}, 0);
        // R9 idle pixels accepted
        for (int g = 0; g < 20; g++) send_px(PIX_W'(g * 5), g == 0);
        chk(pix_ready == 1'b1, "R9 idle ready", pix_ready, 1);
        idle_px();

        // Run 1: zero periods means one (R6); junk before SOF (R5)
        do_start(0);
        for (int j = 0; j < 30; j++) send_px(PIX_W'(3000 + j), 1'b0);
        idle_px();
        for (int f = 0; f < NF; f++) send_frame(f, 1, NPIX);
        @(negedge clk);
        chk(done == 1'b1, "R6 one period", done, 1);
        readout(1'b1);
        chk(done == 1'b1, "R7 done held", done, 1);

        // Run 2: two periods with a mid-frame SOF resync (R5)
        do_start(2);
        send_frame(0, 2, 40);
        for (int f = 0; f < 2 * NF; f++) begin
            if (f == 2 * NF - 1) begin
                @(negedge clk);
                chk(done == 1'b0, "R6 not yet", done, 0);
            end
            send_frame(f, 2, NPIX);
        end
        readout(1'b1);

        // Run 3: restart mid-run (R8), then one period of weight probes (R3)
        do_start(3);
        for (int f = 0; f < 3; f++) send_frame(f, 3, NPIX);
        chk(done == 1'b0, "R8 mid-run", done, 0);
        do_start(1);
        for (int f = 0; f < NF; f++) send_frame(f, 9, NPIX);
        readout(1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule